// File: doc/BRIEF.md
# Serial Display Row Writer

This block lets a host processor update a small dot-matrix display memory over a four-wire serial link: a shift clock, a data line, a latch strobe and a word-type select. Bits are collected in a shift register on each rising edge of the shift clock. The select line decides what the next strobe means. In address mode the strobe turns the most recent eight bits into a row address. In data mode it writes the most recent row of segment bits into the display memory.

Up to four writers can share one link. Each one has two strapped identity pins. An address word carries a two-bit identity field, and only the writer whose straps match it takes the row address. Data strobes always write to the row that the writer itself last accepted. The display memory is a simple dual-port array, and its read port feeds the panel scan logic. All serial inputs are synchronized into the system clock. The link's clock and strobe are detected as edges and are never used as clocks.

Top module: `dsw_serial_writer`

## Requirements
- R1: Serial data is taken only on rising edges of the shift clock. In a segment word the first bit shifted in lands in column COLS-1 (read bit 63 by default) and the last bit lands in column 0, with 1 meaning a lit dot.
- R2: In address mode (select high) the word is sent least significant bit first, and the last eight bits before the strobe falls are the word. Bit 0 is a marker that must be 1, bits 1 to 3 are the row number (bit 1 least significant), bits 4 and 5 are the identity field (bit 4 compared with strap bit 0, bit 5 with strap bit 1), and bits 6 and 7 are ignored. A valid word with a matching identity sets the stored row.
- R3: An address word whose identity field differs from the strap pins leaves the stored row unchanged.
- R4: An address word whose marker bit is 0 leaves the stored row unchanged, even when the identity field matches.
- R5: A falling strobe in data mode writes the shift contents into the stored row exactly once. A falling strobe in address mode writes nothing to the memory.
- R6: The strobe acts as a level latch. While it is high the latched value tracks the shift register, so the row that gets written holds the last COLS bits shifted before the strobe fell, even if shifting continued while the strobe was high or extra leading bits were sent.
- R7: While the power-on-reset hold input is high, no shifting happens and no strobe is acted on. Neither the stored row nor the memory changes.
- R8: After system reset the stored row is 0, so a data word sent before any address word goes to row 0.
- R9: The read port has one clock of latency. rd_data_o shows the row selected by rd_row_i at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_i | input | 1 | Power-on-reset hold; blocks all serial updates while high |
| sck_i | input | 1 | Serial shift clock (asynchronous) |
| sdi_i | input | 1 | Serial data (asynchronous) |
| lat_i | input | 1 | Level latch strobe; the action happens on its falling edge |
| sel_addr_i | input | 1 | 1 = address word, 0 = segment data word |
| cs_strap_i | input | 2 | Strapped identity of this writer |
| rd_row_i | input | ROW_W (3) | Scan read row |
| rd_data_o | output | COLS (64) | Scan read data, registered |

## Verification
The bench builds the block with its defaults: 64 columns, 8 rows, an 8-bit address word, two synchronizer stages and a registered read port. With a 64-bit row, the column order can be checked end to end, using the first bit in against read bit 63. With 8 rows, every row number in the address field can be written and read back. The identity straps are fixed at 2'b10, so the bench can send one matching value and three mismatching ones. At every quiet point the behavioural row memory is compared with every row written so far.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
   // width of the identity field in an address word
   localparam int CS_W = 2;
   // positions of the raw serial inputs inside the synchronizer bus
   localparam int IDX_SCK = 0;
   localparam int IDX_SDI = 1;
   localparam int IDX_LAT = 2;
   localparam int IDX_SEL = 3;
   localparam int IDX_POR = 4;
   localparam int IN_W    = 5;
endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din_i,
   output logic [WIDTH-1:0] dout_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dsw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= din_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/dsw_edge.sv
module dsw_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   generate
      if (RISING) begin : g_rise
         assign edge_o = lvl_i & ~prev_q;
      end else begin : g_fall
         assign edge_o = ~lvl_i & prev_q;
      end
   endgenerate

   // R1: a detected edge lasts a single cycle
   assert_edge_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/dsw_addr_decode.sv
module dsw_addr_decode import dsw_pkg::*; #(
   parameter int ROW_W = 3,
   parameter int DEC_W = 1 + ROW_W + CS_W
) (
   input  logic [DEC_W-1:0] word_i,
   input  logic [CS_W-1:0]  cs_strap_i,
   output logic             hit_o,
   output logic [ROW_W-1:0] row_o
);
   generate
      if (DEC_W != 1 + ROW_W + CS_W) begin : g_bad_width
         $error("dsw_addr_decode: DEC_W must equal 1 + ROW_W + CS_W");
      end
   endgenerate

   logic             marker;
   logic [CS_W-1:0]  ident;

   assign marker = word_i[0];
   assign row_o  = word_i[ROW_W:1];
   assign ident  = word_i[DEC_W-1:ROW_W+1];
   assign hit_o  = marker && (ident == cs_strap_i);
endmodule

// File: rtl/dsw_row_ram.sv
module dsw_row_ram #(
   parameter int ROWS     = 8,
   parameter int COLS     = 64,
   parameter bit READ_REG = 1'b1,
   localparam int ROW_W   = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic [ROW_W-1:0] wa_i,
   input  logic [COLS-1:0]  wd_i,
   input  logic [ROW_W-1:0] ra_i,
   output logic [COLS-1:0]  rd_o
);
   logic [COLS-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (we_i) mem[wa_i] <= wd_i;
   end

   generate
      if (READ_REG) begin : g_reg_read
         always_ff @(posedge clk) rd_o <= mem[ra_i];
      end else begin : g_comb_read
         assign rd_o = mem[ra_i];
      end
   endgenerate
endmodule

// File: rtl/dsw_serial_writer.sv
module dsw_serial_writer import dsw_pkg::*; #(
   parameter int COLS        = 64,
   parameter int ROWS        = 8,
   parameter int ADDR_BITS   = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_REG    = 1'b1,
   localparam int ROW_W      = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_i,
   input  logic             sck_i,
   input  logic             sdi_i,
   input  logic             lat_i,
   input  logic             sel_addr_i,
   input  logic [1:0]       cs_strap_i,
   input  logic [ROW_W-1:0] rd_row_i,
   output logic [COLS-1:0]  rd_data_o
);
   localparam int DEC_W = 1 + ROW_W + CS_W;

   generate
      if (ROWS != (1 << ROW_W)) begin : g_bad_rows
         $error("dsw_serial_writer: ROWS must be a power of two");
      end
      if (ADDR_BITS < DEC_W) begin : g_bad_addr
         $error("dsw_serial_writer: ADDR_BITS too small for marker, row and identity");
      end
      if (COLS < ADDR_BITS) begin : g_bad_cols
         $error("dsw_serial_writer: COLS must cover an address word");
      end
   endgenerate

   // ---- synchronize and detect edges ----
   logic [IN_W-1:0] raw, lvl;
   logic            sck_rise, lat_fall;
   logic            sdi_s, lat_s, sel_s, por_s;

   assign raw[IDX_SCK] = sck_i;
   assign raw[IDX_SDI] = sdi_i;
   assign raw[IDX_LAT] = lat_i;
   assign raw[IDX_SEL] = sel_addr_i;
   assign raw[IDX_POR] = por_i;

   dsw_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din_i(raw), .dout_o(lvl));

   dsw_edge #(.RISING(1'b1)) u_sck_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[IDX_SCK]), .edge_o(sck_rise));

   dsw_edge #(.RISING(1'b0)) u_lat_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl[IDX_LAT]), .edge_o(lat_fall));

   assign sdi_s = lvl[IDX_SDI];
   assign lat_s = lvl[IDX_LAT];
   assign sel_s = lvl[IDX_SEL];
   assign por_s = lvl[IDX_POR];

   // ---- shift register: first bit in ends at the top column ----
   logic [COLS-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                   sr_q <= '0;
      else if (sck_rise && !por_s)  sr_q <= {sr_q[COLS-2:0], sdi_s};
   end

   // ---- level latch: tracks the shift register while the strobe is high ----
   logic [COLS-1:0] latch_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     latch_q <= '0;
      else if (lat_s) latch_q <= sr_q;
   end

   // ---- address word, restored to arrival order (bit 0 first) ----
   logic [DEC_W-1:0] dec_word;
   logic             addr_hit;
   logic [ROW_W-1:0] addr_row;

   always_comb begin
      for (int k = 0; k < DEC_W; k++) dec_word[k] = latch_q[ADDR_BITS-1-k];
   end

   dsw_addr_decode #(.ROW_W(ROW_W), .DEC_W(DEC_W)) u_dec (
      .word_i(dec_word), .cs_strap_i(cs_strap_i), .hit_o(addr_hit), .row_o(addr_row));

   // ---- stored row and write strobe ----
   logic             addr_take, ram_we;
   logic [ROW_W-1:0] row_q;

   assign addr_take = lat_fall && sel_s && !por_s && addr_hit;
   assign ram_we    = lat_fall && !sel_s && !por_s;

   always_ff @(posedge clk) begin
      if (!rst_n)         row_q <= '0;
      else if (addr_take) row_q <= addr_row;
   end

   dsw_row_ram #(.ROWS(ROWS), .COLS(COLS), .READ_REG(READ_REG)) u_ram (
      .clk(clk), .we_i(ram_we), .wa_i(row_q), .wd_i(latch_q),
      .ra_i(rd_row_i), .rd_o(rd_data_o));

   // ---- assertions ----
   // R7: the hold input freezes the shift path
   assert_por_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      por_s |=> $stable(sr_q));

   // R3: the row moves only after an address-mode strobe
   assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(lat_fall && sel_s) |=> $stable(row_q));

   // R4: a row change needs the marker bit in the latched word
   assert_row_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_q) |-> $past(latch_q[ADDR_BITS-1]));

   // R5: a data strobe gives a single write cycle
   assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);

   // R5: no memory write in address mode
   assert_no_addr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |-> !ram_we);
endmodule

// File: tb/dsw_serial_writer_test.sv
module dsw_serial_writer_test;
   localparam int COLS = 64;
   localparam int ROWS = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            por = 1'b0, sck = 1'b0, sdi = 1'b0, lat = 1'b0, sel = 1'b0;
   logic [1:0]      strap = 2'b10;
   logic [2:0]      rd_row = '0;
   logic [COLS-1:0] rd_data;

   always #10 clk = ~clk;

   dsw_serial_writer uut (
      .clk(clk), .rst_n(rst_n), .por_i(por), .sck_i(sck), .sdi_i(sdi),
      .lat_i(lat), .sel_addr_i(sel), .cs_strap_i(strap),
      .rd_row_i(rd_row), .rd_data_o(rd_data));

   int checks = 0, fails = 0;
   bit done = 1'b0;

   // behavioural reference
   logic [COLS-1:0] ref_mem [ROWS];
   bit              ref_valid [ROWS];
   int              ref_row = 0;

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, logic [COLS-1:0] act, logic [COLS-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send_bit(bit b);
      sck = 1'b0; sdi = b; tick(4);
      sck = 1'b1; tick(4);
      sck = 1'b0;
   endtask

   task automatic strobe();
      lat = 1'b1; tick(4);
      lat = 1'b0; tick(10);
   endtask

   task automatic send_addr(logic [2:0] row, logic [1:0] cs, bit mark, logic [1:0] pad);
      logic [7:0] w;
      w = {pad, cs, row, mark};
      sel = 1'b1; tick(4);
      for (int k = 0; k < 8; k++) send_bit(w[k]);
      strobe();
      if (!por && mark && cs == strap) ref_row = row;
   endtask

   task automatic send_data(logic [COLS-1:0] d, int junk, bit early);
      sel = 1'b0; tick(4);
      if (early) lat = 1'b1;
      for (int j = 0; j < junk; j++) send_bit(j[0]);
      for (int k = COLS-1; k >= 0; k--) send_bit(d[k]);
      if (early) begin
         tick(4); lat = 1'b0; tick(10);
      end else begin
         strobe();
      end
      if (!por) begin
         ref_mem[ref_row]   = d;
         ref_valid[ref_row] = 1'b1;
      end
   endtask

   task automatic check_rows(string req);
      for (int r = 0; r < ROWS; r++) begin
         if (ref_valid[r]) begin
            rd_row = r[2:0];
            tick(1);
            chk(req, rd_data, ref_mem[r]);
         end
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < ROWS; r++) ref_valid[r] = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R8: data before any address goes to row 0
      send_data(64'h0123_4567_89AB_CDEF, 0, 1'b0);
      check_rows("R8");

      // R2: matching address words select rows
      send_addr(3'd3, 2'b10, 1'b1, 2'b01);
      send_data(64'hDEAD_BEEF_0000_FFFF, 0, 1'b0);
      send_addr(3'd5, 2'b10, 1'b1, 2'b11);
      send_data(64'h5555_AAAA_3333_CCCC, 0, 1'b0);
      check_rows("R2");

      // R3: mismatching identities leave row 5 selected
      send_addr(3'd6, 2'b01, 1'b1, 2'b00);
      send_addr(3'd1, 2'b00, 1'b1, 2'b00);
      send_addr(3'd2, 2'b11, 1'b1, 2'b00);
      send_data(64'h1111_2222_3333_4444, 0, 1'b0);
      check_rows("R3");

      // R4: marker bit 0 ignored
      send_addr(3'd2, 2'b10, 1'b0, 2'b00);
      send_data(64'h9999_8888_7777_6666, 0, 1'b0);
      check_rows("R4");

      // R5: an address strobe writes nothing
      send_addr(3'd7, 2'b10, 1'b1, 2'b10);
      check_rows("R5");
      send_data(64'hF0F0_0F0F_F0F0_0F0F, 0, 1'b0);
      check_rows("R5");

      // R6: strobe held high while shifting, with extra leading bits
      send_data(64'h0BAD_CAFE_1234_5678, 21, 1'b1);
      check_rows("R6");

      // R1: first bit shifted lands at column 63
      send_addr(3'd4, 2'b10, 1'b1, 2'b00);
      send_data(64'h8000_0000_0000_0000, 0, 1'b0);
      rd_row = 3'd4; tick(1);
      chk("R1", {63'd0, rd_data[63]}, 64'd1);
      chk("R1", {1'b0, rd_data[62:0]}, 64'd0);
      send_data(64'h0000_0000_0000_0001, 0, 1'b0);
      rd_row = 3'd4; tick(1);
      chk("R1", rd_data, 64'h1);

      // R7: hold input blocks everything
      por = 1'b1; tick(6);
      send_addr(3'd0, 2'b10, 1'b1, 2'b00);
      send_data(64'hFFFF_FFFF_FFFF_FFFF, 0, 1'b0);
      por = 1'b0; tick(6);
      check_rows("R7");
      send_data(64'h7E7E_7E7E_8181_8181, 0, 1'b0);
      check_rows("R7");

      // fill every row
      for (int r = 0; r < ROWS; r++) begin
         send_addr(r[2:0], 2'b10, 1'b1, r[1:0]);
         send_data({8{r[2:0], 5'h15}} ^ 64'hC3A5_5A3C_0FF0_9669, 0, 1'b0);
      end
      check_rows("R2");

      // R9: one clock of read latency
      rd_row = 3'd2; tick(1);
      rd_row = 3'd6; #1;
      chk("R9", rd_data, ref_mem[2]);
      tick(1);
      chk("R9", rd_data, ref_mem[6]);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule